// File: doc/BRIEF.md
# Direct-Mapped Data Translation Buffer

This block turns the virtual address of a load or store into a physical address using 64 software-loaded entries, each holding one translation. The entry is chosen by the low six bits of the virtual page number (8 KiB pages). An entry answers only when it is marked valid and the upper page bits it holds agree with the request. There is no hardware refill. A lookup that finds nothing raises a miss that traps to the fixed vector 0x900. The faulting address is kept in a register so that the handler can compute the index and write the entry's match and translate words through the write port.

The lookup path is purely combinational: hit, miss, deny, trap vector and physical address all answer in the request cycle. Table writes are committed at the clock edge, so an access retried after the handler returns sees the new entry. With translation switched off, addresses pass through unchanged and no miss can occur.

Top module: `dtlb_direct`

## Requirements
- R1: After reset every entry is invalid, so any lookup with translation enabled misses and `fault_addr` reads 0.
- R2: A lookup uses index `lk_vaddr[18:13]`. It hits only if that entry's valid bit is set and its stored tag equals `lk_vaddr[31:19]`. `lk_hit` and `lk_miss` are never both high.
- R3: On a hit, `lk_paddr` is the entry's physical page number (translate word bits 31:13) followed by `lk_vaddr[12:0]`. On a miss, `lk_paddr` is 0.
- R4: `lk_miss` is high in the request cycle of a missing lookup. In that cycle `trap_vec` is 0x900; otherwise `trap_vec` is 0.
- R5: From the cycle after a miss, `fault_addr` holds that miss's virtual address. It keeps its value over hits, idle cycles and bypassed lookups.
- R6: A write is visible from the next cycle. A lookup in the same cycle as a write sees the old contents.
- R7: Writing a match word with bit 0 clear invalidates the entry. A match word carries the tag in bits 31:19 and the valid bit in bit 0 (`wr_sel`=0).
- R8: With `xlate_en` low, a request returns `lk_paddr` = `lk_vaddr`, `lk_hit`=1, `lk_miss`=0 and `lk_deny`=0.
- R9: The translate word (`wr_sel`=1) holds load-enable in bit 0 and store-enable in bit 1. `lk_deny` is high on a hit whose enable for the access type (`lk_store`) is clear. A denied access is still a hit and raises no miss.
- R10: With `lk_req` low, `lk_hit`, `lk_miss` and `lk_deny` are all low.
- R11: Each index holds one translation. Refilling an index replaces its previous page, and writing one index leaves all the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Translation enable; low selects pass-through |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | 1 = store access, 0 = load access |
| lk_paddr | output | 32 | Physical address |
| lk_hit | output | 1 | Lookup found a valid matching entry (or bypass) |
| lk_miss | output | 1 | Lookup found no entry; miss exception |
| lk_deny | output | 1 | Hit, but the access type is not enabled |
| trap_vec | output | 12 | Exception vector, 0x900 on a miss |
| fault_addr | output | 32 | Virtual address of the latest miss |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | 0 = match word, 1 = translate word |
| wr_idx | input | 6 | Entry index to write |
| wr_data | input | 32 | Word written |

## Verification
The bench targets the write/lookup race. A design that bypassed a same-cycle write would report a hit one cycle early, and one that delayed the write further would keep missing after the retry. It also checks two entries that share an index but differ in upper page bits: a design that compared too few tag bits would wrongly hit on the alias. Further checks cover a store to a load-only page, where a design that folds permission into the hit would raise a spurious miss. Finally, `fault_addr` is watched across later hits, so a design that recorded the address on every lookup would lose the faulting value.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
    localparam int VA_W     = 32;
    localparam int PG_SHIFT = 13;
    localparam int IDX_W    = 6;
    localparam int VEC_W    = 12;
    localparam logic [VEC_W-1:0] MISS_VEC = 12'h900;

    typedef enum logic {
        SEL_MATCH = 1'b0,
        SEL_XLATE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic st_en;
        logic ld_en;
    } perm_t;
endpackage

// File: rtl/dtlb_match_array.sv
module dtlb_match_array #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid
);
    localparam int N_ENT = 1 << IDX_W;

    logic [N_ENT-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [N_ENT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/dtlb_xlate_array.sv
module dtlb_xlate_array
    import dtlb_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int PPN_W = 19
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PPN_W-1:0] wr_ppn,
    input  perm_t            wr_perm,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PPN_W-1:0] rd_ppn,
    output perm_t            rd_perm
);
    localparam int N_ENT = 1 << IDX_W;

    logic [PPN_W-1:0] ppn_q  [N_ENT];
    perm_t            perm_q [N_ENT];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ppn_q[wr_idx]  <= wr_ppn;
            perm_q[wr_idx] <= wr_perm;
        end
    end

    assign rd_ppn  = ppn_q[rd_idx];
    assign rd_perm = perm_q[rd_idx];
endmodule

// File: rtl/dtlb_fault_capture.sv
module dtlb_fault_capture #(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [VA_W-1:0] addr_in,
    output logic [VA_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (capture) begin
            addr_q <= addr_in;
        end
    end
endmodule

// File: rtl/dtlb_direct.sv
module dtlb_direct
    import dtlb_pkg::*;
#(
    parameter int AW    = dtlb_pkg::VA_W,
    parameter int PGS   = dtlb_pkg::PG_SHIFT,
    parameter int IW    = dtlb_pkg::IDX_W,
    parameter int VW    = dtlb_pkg::VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xlate_en,
    input  logic          lk_req,
    input  logic [AW-1:0] lk_vaddr,
    input  logic          lk_store,
    output logic [AW-1:0] lk_paddr,
    output logic          lk_hit,
    output logic          lk_miss,
    output logic          lk_deny,
    output logic [VW-1:0] trap_vec,
    output logic [AW-1:0] fault_addr,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data
);
    localparam int PPN_W = AW - PGS;
    localparam int TAG_W = AW - PGS - IW;
    localparam int TAG_LO = PGS + IW;

    logic [IW-1:0]    rd_idx;
    logic [TAG_W-1:0] rd_tag;
    logic             rd_valid;
    logic [PPN_W-1:0] rd_ppn;
    perm_t            rd_perm;
    logic             wr_match, wr_xlate;
    logic             tag_eq, allowed;

    assign rd_idx   = lk_vaddr[PGS +: IW];
    assign wr_match = wr_en && (reg_sel_e'(wr_sel) == SEL_MATCH);
    assign wr_xlate = wr_en && (reg_sel_e'(wr_sel) == SEL_XLATE);

    dtlb_match_array #(.IDX_W(IW), .TAG_W(TAG_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_match),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_data[AW-1:TAG_LO]),
        .wr_valid (wr_data[0]),
        .rd_idx   (rd_idx),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid)
    );

    dtlb_xlate_array #(.IDX_W(IW), .PPN_W(PPN_W)) u_xlate (
        .clk     (clk),
        .wr_en   (wr_xlate),
        .wr_idx  (wr_idx),
        .wr_ppn  (wr_data[AW-1:PGS]),
        .wr_perm (perm_t'(wr_data[1:0])),
        .rd_idx  (rd_idx),
        .rd_ppn  (rd_ppn),
        .rd_perm (rd_perm)
    );

    assign tag_eq  = rd_valid && (rd_tag == lk_vaddr[AW-1:TAG_LO]);
    assign allowed = lk_store ? rd_perm.st_en : rd_perm.ld_en;

    always_comb begin
        lk_hit   = 1'b0;
        lk_miss  = 1'b0;
        lk_deny  = 1'b0;
        lk_paddr = '0;
        trap_vec = '0;
        if (lk_req) begin
            if (!xlate_en) begin
                lk_hit   = 1'b1;
                lk_paddr = lk_vaddr;
            end else if (tag_eq) begin
                lk_hit   = 1'b1;
                lk_deny  = !allowed;
                lk_paddr = {rd_ppn, lk_vaddr[PGS-1:0]};
            end else begin
                lk_miss  = 1'b1;
                trap_vec = MISS_VEC;
            end
        end
    end

    dtlb_fault_capture #(.VA_W(AW)) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (lk_miss),
        .addr_in (lk_vaddr),
        .addr_q  (fault_addr)
    );
endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker #(
    parameter int AW = 32,
    parameter int PGS = 13,
    parameter int IW = 6,
    parameter int VW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xlate_en,
    input logic          lk_req,
    input logic [AW-1:0] lk_vaddr,
    input logic [AW-1:0] lk_paddr,
    input logic          lk_hit,
    input logic          lk_miss,
    input logic          lk_deny,
    input logic [VW-1:0] trap_vec,
    input logic [AW-1:0] fault_addr,
    input logic          wr_en,
    input logic          wr_sel,
    input logic [IW-1:0] wr_idx,
    input logic [AW-1:0] wr_data
);
    // R2
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R4
    miss_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> trap_vec == 12'h900);

    // R5
    fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |=> fault_addr == $past(lk_vaddr));

    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_miss |=> $stable(fault_addr));

    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !xlate_en) |-> (lk_hit && !lk_miss && lk_paddr == lk_vaddr));

    // R9
    deny_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_deny |-> lk_hit);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> (!lk_hit && !lk_miss && !lk_deny));

    // R7
    inval_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !wr_data[0]) |=>
        !(lk_req && xlate_en && lk_vaddr[PGS +: IW] == $past(wr_idx) && lk_hit));
endmodule

bind dtlb_direct dtlb_checker #(.AW(AW), .PGS(PGS), .IW(IW), .VW(VW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xlate_en   (xlate_en),
    .lk_req     (lk_req),
    .lk_vaddr   (lk_vaddr),
    .lk_paddr   (lk_paddr),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .lk_deny    (lk_deny),
    .trap_vec   (trap_vec),
    .fault_addr (fault_addr),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data)
);

// File: tb/tb_dtlb_direct.sv
module tb_dtlb_direct;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b1;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_store = 1'b0;
    logic [31:0] lk_paddr;
    logic        lk_hit, lk_miss, lk_deny;
    logic [11:0] trap_vec;
    logic [31:0] fault_addr;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dtlb_direct dut (
        .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .lk_req(lk_req),
        .lk_vaddr(lk_vaddr), .lk_store(lk_store), .lk_paddr(lk_paddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_deny(lk_deny),
        .trap_vec(trap_vec), .fault_addr(fault_addr), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tbl_write(input logic sel, input logic [5:0] idx, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic st);
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = va; lk_store = st;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        lk_req = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 fault_addr after reset", fault_addr, 32'h0);
        look(32'h0000_2000, 1'b0);
        chk("R1 miss after reset", {31'b0, lk_miss}, 32'd1);
        chk("R1 no hit after reset", {31'b0, lk_hit}, 32'd0);
        chk("R4 trap vector", {20'b0, trap_vec}, 32'h900);
        chk("R3 paddr zero on miss", lk_paddr, 32'h0);
        idle();
        chk("R5 fault address captured", fault_addr, 32'h0000_2000);
        chk("R10 idle hit", {31'b0, lk_hit}, 32'd0);
        chk("R10 idle miss", {31'b0, lk_miss}, 32'd0);
        chk("R4 idle vector zero", {20'b0, trap_vec}, 32'h0);
    endtask

    task automatic t_bypass();
        xlate_en = 1'b0;
        look(32'hC000_1234, 1'b1);
        chk("R8 bypass paddr", lk_paddr, 32'hC000_1234);
        chk("R8 bypass hit", {31'b0, lk_hit}, 32'd1);
        chk("R8 bypass miss", {31'b0, lk_miss}, 32'd0);
        chk("R8 bypass deny", {31'b0, lk_deny}, 32'd0);
        idle();
        chk("R5 fault held over bypass", fault_addr, 32'h0000_2000);
        xlate_en = 1'b1;
    endtask

    task automatic t_fill_hit();
        tbl_write(1'b1, 6'd0, 32'h0100_0003);
        tbl_write(1'b0, 6'd0, 32'hC000_0001);
        look(32'hC000_0010, 1'b0);
        chk("R2 hit after fill", {31'b0, lk_hit}, 32'd1);
        chk("R3 translated paddr", lk_paddr, 32'h0100_0010);
        look(32'hC000_1FFC, 1'b1);
        chk("R3 page offset kept", lk_paddr, 32'h0100_1FFC);
        chk("R9 store allowed", {31'b0, lk_deny}, 32'd0);
        idle();
    endtask

    task automatic t_tag_mismatch();
        look(32'h4000_0010, 1'b0);
        chk("R2 tag mismatch misses", {31'b0, lk_miss}, 32'd1);
        look(32'hC000_0020, 1'b0);
        chk("R2 original still hits", {31'b0, lk_hit}, 32'd1);
        idle();
        chk("R5 fault held over hit", fault_addr, 32'h4000_0010);
    endtask

    task automatic t_same_cycle();
        tbl_write(1'b1, 6'd5, 32'h000E_E003);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_idx = 6'd5; wr_data = 32'h0000_A001;
        lk_req = 1'b1; lk_vaddr = 32'h0000_A004; lk_store = 1'b0;
        #1;
        chk("R6 same-cycle lookup sees old", {31'b0, lk_miss}, 32'd1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R6 retry hits", {31'b0, lk_hit}, 32'd1);
        chk("R6 retry paddr", lk_paddr, 32'h000E_E004);
        idle();
    endtask

    task automatic t_perm();
        tbl_write(1'b1, 6'd7, 32'h0002_0001);
        tbl_write(1'b0, 6'd7, 32'h0000_E001);
        look(32'h0000_E100, 1'b0);
        chk("R9 load allowed", {31'b0, lk_deny}, 32'd0);
        chk("R9 load paddr", lk_paddr, 32'h0002_0100);
        look(32'h0000_E100, 1'b1);
        chk("R9 store denied", {31'b0, lk_deny}, 32'd1);
        chk("R9 denied still hit", {31'b0, lk_hit}, 32'd1);
        chk("R9 denied no miss", {31'b0, lk_miss}, 32'd0);
        idle();
    endtask

    task automatic t_inval();
        tbl_write(1'b0, 6'd0, 32'h0000_0000);
        look(32'hC000_0010, 1'b0);
        chk("R7 invalidated entry misses", {31'b0, lk_miss}, 32'd1);
        look(32'h0000_A008, 1'b0);
        chk("R11 other index unaffected", {31'b0, lk_hit}, 32'd1);
        idle();
    endtask

    task automatic t_alias();
        tbl_write(1'b0, 6'd5, 32'h0800_A001);
        look(32'h0000_A004, 1'b0);
        chk("R11 old page replaced", {31'b0, lk_miss}, 32'd1);
        look(32'h0800_A004, 1'b0);
        chk("R11 new page hits", {31'b0, lk_hit}, 32'd1);
        chk("R11 new page paddr", lk_paddr, 32'h000E_E004);
        idle();
        lk_req = 1'b0;
        #1;
        chk("R10 idle deny", {31'b0, lk_deny}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_fill_hit();
        t_tag_mismatch();
        t_same_cycle();
        t_perm();
        t_inval();
        t_alias();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule